// File: doc/BRIEF.md
# Dual-Channel Wiper Register Controller with SPI Access

This block is the digital control core of a two-channel digital potentiometer. It keeps one 7-bit wiper code per channel, where code 00h puts the wiper next to the low terminal and 7Fh next to the high terminal. Each channel also has a stored start-up code in a non-volatile array. The array holds five more general-purpose bytes. A control register selects which storage the channel addresses reach, enables shutdown and reports a busy flag. A host reaches all of this through a 16-bit SPI mode-0 slave port. The resistor ladder and the analog switches are outside the block; it only drives the codes and a shutdown line per channel.

After power-on reset both wipers sit at mid-scale (40h). After a start-up delay that stands for the storage becoming readable, each wiper is loaded from its stored start-up code. The non-volatile array is modelled as registers with a programmable commit delay. While a commit is pending, the busy flag is high and every register write is refused.

Top module: `dpot_ctrl_core`

## Requirements
- R1: While reset is asserted and for PWRUP_CYCLES clocks after it is released, both wiper codes read 40h. After that, each wiper holds the start-up code stored for its channel (defaults 15h for channel 0 and 6Ah for channel 1), and register writes are refused until this load has happened.
- R2: The register address is 4 bits. Address 0 is channel 0, address 1 is channel 1, addresses 2 to 6 are general-purpose non-volatile bytes (reset content 00h), and address 8 is the control register. Every other address reads 00h and ignores writes, which means no busy flag and no change anywhere.
- R3: Control bit 7 selects the bank for addresses 0 and 1. When it is 1, reads return {0, wiper code}. Writes load data[6:0] into that wiper at once and start no non-volatile write.
- R4: When control bit 7 is 0, addresses 0 and 1 read the stored start-up code. A write stores data[6:0] there after the commit delay, and it also loads the same value into the channel's wiper when the frame ends.
- R5: Any accepted write to addresses 0 or 1 with bit 7 at 0, or to addresses 2 to 6, sets control bit 5 (busy) for NV_WR_CYCLES clocks. The array takes the new byte when busy clears, and busy can be polled by reading the control register.
- R6: While busy is 1, writes to any address are ignored. This covers the wipers, the start-up codes, the general-purpose bytes and the control register.
- R7: The control register resets to 40h. A read returns {bank, shutdown-enable, busy, 00000b}. Bit 5 and bits 4:0 cannot be written and always read as the live busy state and zeros.
- R8: Each channel's shutdown output is 1 exactly when control bit 6 is 0 or the input shdn_in_n is 0.
- R9: A frame is 16 SCK cycles, MSB first, with data sampled on rising SCK. Byte 1 carries the address in [7:4] and the opcode in [3:2], where 01b is read and 10b is write. Byte 2 is the write data or the read data. Opcodes 00b and 11b have no effect.
- R10: If chip select rises before the 16th rising SCK edge, the frame is dropped and no register changes.
- R11: During byte 2 of a read, spi_miso presents the read byte MSB first and changes after falling SCK edges. It is 0 whenever spi_cs_n is high and during byte 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host, 0 when not selected |
| shdn_in_n | input | 1 | External shutdown request, active low |
| wiper_codes | output | CHANNELS*CODE_W | Wiper codes; channel 0 in the low bits |
| chan_shdn | output | CHANNELS | Shutdown per channel, active high |

## Verification
The bench looks at the wipers in the window before the start-up load and again after it. A design that skipped the mid-scale phase, or loaded the wrong channel, shows the wrong code at one of those two points. It probes the lockout from inside the busy window. It writes the control register and the other channel while a commit is pending, then checks that neither took effect and that busy clears by itself. A design that leaked writes or never cleared busy would fail here. It also checks the bank selection by reading the same address with bit 7 set and with bit 7 clear, and it expects different values, because a write-through that wrongly skipped the array would return the volatile code both times. The remaining probes are frames cut short, opcode 11b, writes to reserved addresses, and attempts to set the read-only control bits. In each case a permissive design would change the wiper, raise busy or return non-zero bits.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int BYTE_W = 8;

   // register address map (4-bit address field)
   localparam logic [3:0] ADR_CH0  = 4'd0;
   localparam logic [3:0] ADR_CH1  = 4'd1;
   localparam logic [3:0] ADR_GP_LO = 4'd2;
   localparam logic [3:0] ADR_GP_HI = 4'd6;
   localparam logic [3:0] ADR_CTRL = 4'd8;

   // control register bit positions
   localparam int CTRL_BANK_BIT = 7;
   localparam int CTRL_SHDN_BIT = 6;
   localparam int CTRL_BUSY_BIT = 5;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10,
      OP_RSVD  = 2'b11
   } spi_op_e;
endpackage

// File: rtl/dpot_spi_slave.sv
module dpot_spi_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              hdr_valid,
   output logic [BYTE_W-1:0] hdr_byte,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              frame_done,
   output logic [BYTE_W-1:0] data_byte
);
   localparam int FRAME_BITS = 2 * BYTE_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BYTE_W < 8) begin : g_chk_byte
      $error("BYTE_W must be at least 8");
   end

   logic [SYNC_STAGES:0]   sck_s;
   logic [SYNC_STAGES-1:0] cs_s;
   logic [SYNC_STAGES-1:0] mosi_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s  <= '0;
         cs_s   <= '1;
         mosi_s <= '0;
      end else begin
         sck_s  <= {sck_s[SYNC_STAGES-1:0], spi_sck};
         cs_s   <= {cs_s[SYNC_STAGES-2:0], spi_cs_n};
         mosi_s <= {mosi_s[SYNC_STAGES-2:0], spi_mosi};
      end
   end

   logic sck_now, sck_prev, cs_now, mosi_now, sck_rise, sck_fall;
   assign sck_now  = sck_s[SYNC_STAGES-1];
   assign sck_prev = sck_s[SYNC_STAGES];
   assign cs_now   = cs_s[SYNC_STAGES-1];
   assign mosi_now = mosi_s[SYNC_STAGES-1];
   assign sck_rise = sck_now & ~sck_prev;
   assign sck_fall = ~sck_now & sck_prev;

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_buf;
   logic              miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_buf     <= '0;
         miso_q     <= 1'b0;
         hdr_valid  <= 1'b0;
         hdr_byte   <= '0;
         frame_done <= 1'b0;
         data_byte  <= '0;
      end else begin
         hdr_valid  <= 1'b0;
         frame_done <= 1'b0;
         if (cs_now) begin
            bit_cnt <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (sck_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
               rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_now};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                  hdr_byte  <= {rx_sh, mosi_now};
                  hdr_valid <= 1'b1;
               end
               if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                  data_byte  <= {rx_sh, mosi_now};
                  frame_done <= 1'b1;
               end
            end
            if (hdr_valid) begin
               tx_buf <= rd_byte;
            end else if (sck_fall && bit_cnt >= CNT_W'(BYTE_W)) begin
               miso_q <= tx_buf[BYTE_W-1];
               tx_buf <= {tx_buf[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign spi_miso = ~spi_cs_n & miso_q;

   assert_abort_clears_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_now |=> (bit_cnt == '0));
   assert_miso_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_now |=> !miso_q);
   assert_frame_len_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_BITS));
   assert_hdr_data_excl_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && frame_done));
endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store #(
   parameter int                       DEPTH     = 7,
   parameter int                       WIDTH     = 8,
   parameter int                       WR_CYCLES = 1000,
   parameter logic [DEPTH*WIDTH-1:0]   INIT      = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_req,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [WIDTH-1:0]         wr_data,
   output logic                     busy,
   output logic [DEPTH*WIDTH-1:0]   mem_flat
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int TMR_W = $clog2(WR_CYCLES + 1);

   if (WR_CYCLES < 1) begin : g_chk_cycles
      $error("WR_CYCLES must be at least 1");
   end
   if (DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [IDX_W-1:0] pend_idx;
   logic [WIDTH-1:0] pend_data;
   logic [TMR_W-1:0] timer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= INIT[i*WIDTH +: WIDTH];
         end
         busy      <= 1'b0;
         timer     <= '0;
         pend_idx  <= '0;
         pend_data <= '0;
      end else if (busy) begin
         if (timer == TMR_W'(WR_CYCLES - 1)) begin
            mem[pend_idx] <= pend_data;
            busy          <= 1'b0;
            timer         <= '0;
         end else begin
            timer <= timer + 1'b1;
         end
      end else if (wr_req) begin
         busy      <= 1'b1;
         pend_idx  <= wr_idx;
         pend_data <= wr_data;
         timer     <= '0;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign mem_flat[g*WIDTH +: WIDTH] = mem[g];
   end

   assert_busy_start_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy) |=> busy);
   assert_hold_idle_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(mem_flat));
   assert_timer_bound_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      timer < TMR_W'(WR_CYCLES));
   assert_idx_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wr_idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
   parameter int CHANNELS    = 2,
   parameter int CODE_W      = 7,
   parameter int MID_CODE    = 64,
   parameter int LOAD_CYCLES = 20
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CHANNELS*CODE_W-1:0]   load_codes,
   input  logic [CHANNELS-1:0]          wr_en,
   input  logic [CODE_W-1:0]            wr_code,
   output logic                         ready,
   output logic [CHANNELS*CODE_W-1:0]   codes
);
   localparam int LC_W = $clog2(LOAD_CYCLES + 1);
   localparam logic [CODE_W-1:0] MID = CODE_W'(MID_CODE);

   if (LOAD_CYCLES < 1) begin : g_chk_load
      $error("LOAD_CYCLES must be at least 1");
   end
   if (MID_CODE >= (1 << CODE_W)) begin : g_chk_mid
      $error("MID_CODE does not fit CODE_W");
   end

   logic [LC_W-1:0] ld_cnt;
   logic            ld_done;
   assign ld_done = ~ready && (ld_cnt == LC_W'(LOAD_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_cnt <= '0;
         ready  <= 1'b0;
      end else if (!ready) begin
         if (ld_done) begin
            ready <= 1'b1;
         end else begin
            ld_cnt <= ld_cnt + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= MID;
         end else if (ld_done) begin
            code_q <= load_codes[g*CODE_W +: CODE_W];
         end else if (ready && wr_en[g]) begin
            code_q <= wr_code;
         end
      end
      assign codes[g*CODE_W +: CODE_W] = code_q;

      assert_mid_until_ready_R1 : assert property (@(posedge clk) disable iff (!rst_n)
         !ready |-> (code_q == MID));
   end

   assert_ready_sticky_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
   assert_load_on_ready_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (codes == $past(load_codes)));
endmodule

// File: rtl/dpot_ctrl_core.sv
module dpot_ctrl_core
   import dpot_pkg::*;
#(
   parameter int               CHANNELS     = 2,
   parameter int               CODE_W       = 7,
   parameter int               MID_CODE     = 64,
   parameter int               PWRUP_CYCLES = 20,
   parameter int               NV_WR_CYCLES = 1000,
   parameter int               SYNC_STAGES  = 2,
   parameter logic [CODE_W-1:0] IVR0_INIT   = 7'h15,
   parameter logic [CODE_W-1:0] IVR1_INIT   = 7'h6A
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_sck,
   input  logic                       spi_cs_n,
   input  logic                       spi_mosi,
   output logic                       spi_miso,
   input  logic                       shdn_in_n,
   output logic [CHANNELS*CODE_W-1:0] wiper_codes,
   output logic [CHANNELS-1:0]        chan_shdn
);
   localparam int NV_DEPTH = int'(ADR_GP_HI) + 1;
   localparam int IDX_W    = $clog2(NV_DEPTH);
   localparam logic [NV_DEPTH*BYTE_W-1:0] NV_INIT =
      {{((NV_DEPTH - 2) * BYTE_W){1'b0}},
       {(BYTE_W - CODE_W){1'b0}}, IVR1_INIT,
       {(BYTE_W - CODE_W){1'b0}}, IVR0_INIT};

   if (CHANNELS != 2) begin : g_chk_chan
      $error("address map provides exactly two channels");
   end
   if (CODE_W >= BYTE_W) begin : g_chk_code
      $error("CODE_W must be narrower than a byte");
   end

   // SPI front end
   logic              hdr_valid, frame_done;
   logic [BYTE_W-1:0] hdr_byte, data_byte, rd_byte;

   dpot_spi_slave #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_spi (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sck   (spi_sck),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .hdr_valid (hdr_valid),
      .hdr_byte  (hdr_byte),
      .rd_byte   (rd_byte),
      .frame_done(frame_done),
      .data_byte (data_byte)
   );

   logic [3:0] adr;
   spi_op_e    op;
   logic       unused_hdr_bits;
   assign adr             = hdr_byte[7:4];
   assign op              = spi_op_e'(hdr_byte[3:2]);
   assign unused_hdr_bits = ^hdr_byte[1:0];

   // control register
   logic ctl_bank, ctl_shdn_n;
   logic nv_busy, wipers_ready;

   // write decode
   logic                   wr_ok, is_chan, is_gp;
   logic                   nv_req;
   logic [IDX_W-1:0]       nv_idx;
   logic [BYTE_W-1:0]      nv_data;
   logic [CHANNELS-1:0]    wp_en;
   logic [NV_DEPTH*BYTE_W-1:0] nv_flat;

   assign wr_ok   = frame_done && (op == OP_WRITE) && !nv_busy && wipers_ready;
   assign is_chan = (adr == ADR_CH0) || (adr == ADR_CH1);
   assign is_gp   = (adr >= ADR_GP_LO) && (adr <= ADR_GP_HI);

   always_comb begin
      nv_req  = 1'b0;
      nv_idx  = adr[IDX_W-1:0];
      nv_data = data_byte;
      wp_en   = '0;
      if (wr_ok && is_chan) begin
         wp_en[adr[0]] = 1'b1;
         nv_req        = ~ctl_bank;
         nv_data       = {{(BYTE_W - CODE_W){1'b0}}, data_byte[CODE_W-1:0]};
      end else if (wr_ok && is_gp) begin
         nv_req = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_bank   <= 1'b0;
         ctl_shdn_n <= 1'b1;
      end else if (wr_ok && adr == ADR_CTRL) begin
         ctl_bank   <= data_byte[CTRL_BANK_BIT];
         ctl_shdn_n <= data_byte[CTRL_SHDN_BIT];
      end
   end

   dpot_nv_store #(
      .DEPTH    (NV_DEPTH),
      .WIDTH    (BYTE_W),
      .WR_CYCLES(NV_WR_CYCLES),
      .INIT     (NV_INIT)
   ) u_nv (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (nv_req),
      .wr_idx  (nv_idx),
      .wr_data (nv_data),
      .busy    (nv_busy),
      .mem_flat(nv_flat)
   );

   logic [CHANNELS*CODE_W-1:0] ivr_codes;
   for (genvar g = 0; g < CHANNELS; g++) begin : g_ivr
      assign ivr_codes[g*CODE_W +: CODE_W] = nv_flat[g*BYTE_W +: CODE_W];
      assign chan_shdn[g] = ~(ctl_shdn_n & shdn_in_n);
   end

   dpot_wiper_bank #(
      .CHANNELS   (CHANNELS),
      .CODE_W     (CODE_W),
      .MID_CODE   (MID_CODE),
      .LOAD_CYCLES(PWRUP_CYCLES)
   ) u_wipers (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_codes(ivr_codes),
      .wr_en     (wp_en),
      .wr_code   (data_byte[CODE_W-1:0]),
      .ready     (wipers_ready),
      .codes     (wiper_codes)
   );

   // read mux, sampled by the SPI block when the header completes
   always_comb begin
      rd_byte = '0;
      if (is_chan) begin
         if (ctl_bank)
            rd_byte = {{(BYTE_W - CODE_W){1'b0}}, wiper_codes[adr[0]*CODE_W +: CODE_W]};
         else
            rd_byte = {{(BYTE_W - CODE_W){1'b0}}, ivr_codes[adr[0]*CODE_W +: CODE_W]};
      end else if (is_gp) begin
         rd_byte = nv_flat[adr[IDX_W-1:0]*BYTE_W +: BYTE_W];
      end else if (adr == ADR_CTRL) begin
         rd_byte[CTRL_BANK_BIT] = ctl_bank;
         rd_byte[CTRL_SHDN_BIT] = ctl_shdn_n;
         rd_byte[CTRL_BUSY_BIT] = nv_busy;
      end
   end

   assert_lock_wipers_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |=> $stable(wiper_codes));
   assert_lock_ctrl_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |=> $stable({ctl_bank, ctl_shdn_n}));
   assert_bank_no_busy_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!nv_busy && ctl_bank && !(wr_ok && is_gp)) |=> !nv_busy);
   assert_writethrough_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && is_chan) |=> (wiper_codes[adr[0]*CODE_W +: CODE_W] == $past(data_byte[CODE_W-1:0])));
endmodule

// File: tb/dpot_ctrl_core_tb.sv
`timescale 1ns/1ps
module dpot_ctrl_core_tb;
   localparam time CLK_HALF = 2.5ns;
   localparam time SPI_HALF = 40ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic        shdn_in_n = 1'b1;
   logic [13:0] wiper_codes;
   logic [1:0]  chan_shdn;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   dpot_ctrl_core u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sck    (spi_sck),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .spi_miso   (spi_miso),
      .shdn_in_n  (shdn_in_n),
      .wiper_codes(wiper_codes),
      .chan_shdn  (chan_shdn)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic spi_frame(input logic [3:0] adr, input logic [1:0] op,
                            input logic [7:0] wdata, input int nbits,
                            output logic [7:0] rdata);
      logic [15:0] frame;
      frame = {adr, op, 2'b00, wdata};
      rdata = '0;
      @(posedge clk); #1;
      spi_cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = frame[15 - i];
         #(SPI_HALF);
         spi_sck = 1'b1;
         if (i >= 8) rdata[15 - i] = spi_miso;
         #(SPI_HALF);
         spi_sck = 1'b0;
      end
      #(SPI_HALF);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      #(4 * SPI_HALF);
   endtask

   task automatic spi_wr(input logic [3:0] adr, input logic [7:0] d);
      logic [7:0] unused_rd;
      spi_frame(adr, 2'b10, d, 16, unused_rd);
   endtask

   task automatic spi_rd(input logic [3:0] adr, output logic [7:0] d);
      spi_frame(adr, 2'b01, 8'h00, 16, d);
   endtask

   task automatic wait_not_busy(input string req);
      logic [7:0] c;
      int n = 0;
      do begin
         spi_rd(4'd8, c);
         n++;
      end while (c[5] && n < 20);
      check(req, {7'b0, c[5]}, 8'h00);
   endtask

   function automatic logic [7:0] w0();
      return {1'b0, wiper_codes[6:0]};
   endfunction
   function automatic logic [7:0] w1();
      return {1'b0, wiper_codes[13:7]};
   endfunction

   task automatic t_powerup();
      repeat (5) @(posedge clk);
      #1;
      check("R1 mid-scale ch0 in reset", w0(), 8'h40);
      check("R1 mid-scale ch1 in reset", w1(), 8'h40);
      check("R11 miso idle in reset", {7'b0, spi_miso}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      check("R1 mid-scale ch0 before load", w0(), 8'h40);
      check("R1 mid-scale ch1 before load", w1(), 8'h40);
      repeat (40) @(posedge clk);
      #1;
      check("R1 loaded ch0", w0(), 8'h15);
      check("R1 loaded ch1", w1(), 8'h6A);
   endtask

   task automatic t_ctrl_defaults();
      logic [7:0] d;
      spi_rd(4'd8, d);
      check("R7 control default", d, 8'h40);
      check("R8 no shutdown default", {6'b0, chan_shdn}, 8'h00);
      check("R11 miso idle after frame", {7'b0, spi_miso}, 8'h00);
   endtask

   task automatic t_nv_write_busy();
      logic [7:0] d;
      spi_wr(4'd0, 8'hB3);
      check("R4 write-through to wiper ch0", w0(), 8'h33);
      spi_rd(4'd8, d);
      check("R5 busy after nv write", d, 8'h60);
      spi_wr(4'd8, 8'hC0);
      spi_wr(4'd1, 8'h11);
      check("R6 wiper ch1 locked", w1(), 8'h6A);
      wait_not_busy("R5 busy clears");
      spi_rd(4'd8, d);
      check("R6 control write ignored while busy", d, 8'h40);
      spi_rd(4'd0, d);
      check("R4 stored code ch0", d, 8'h33);
      spi_rd(4'd1, d);
      check("R6 stored code ch1 untouched", d, 8'h6A);
   endtask

   task automatic t_volatile_bank();
      logic [7:0] d;
      spi_wr(4'd8, 8'hC0);
      spi_wr(4'd0, 8'hFF);
      check("R3 volatile write ch0", w0(), 8'h7F);
      spi_rd(4'd8, d);
      check("R3 no busy on volatile write", d, 8'hC0);
      spi_rd(4'd0, d);
      check("R3 read wiper bank", d, 8'h7F);
      spi_wr(4'd8, 8'h40);
      spi_rd(4'd0, d);
      check("R3 bank 0 returns stored code", d, 8'h33);
   endtask

   task automatic t_ctrl_readonly();
      logic [7:0] d;
      spi_wr(4'd8, 8'hFF);
      spi_rd(4'd8, d);
      check("R7 read-only bits", d, 8'hC0);
      spi_wr(4'd8, 8'h40);
   endtask

   task automatic t_shutdown();
      logic [7:0] d;
      shdn_in_n = 1'b0; #20;
      check("R8 pin low", {6'b0, chan_shdn}, 8'h03);
      shdn_in_n = 1'b1; #20;
      spi_wr(4'd8, 8'h00);
      check("R8 control bit low", {6'b0, chan_shdn}, 8'h03);
      spi_wr(4'd8, 8'h40);
      check("R8 both high", {6'b0, chan_shdn}, 8'h00);
      spi_rd(4'd8, d);
      check("R8 control restored", d, 8'h40);
   endtask

   task automatic t_gp_reserved();
      logic [7:0] d;
      spi_rd(4'd2, d);
      check("R2 gp reset content", d, 8'h00);
      spi_wr(4'd3, 8'hA5);
      spi_rd(4'd8, d);
      check("R5 busy after gp write", d, 8'h60);
      wait_not_busy("R5 gp busy clears");
      spi_rd(4'd3, d);
      check("R2 gp byte stored", d, 8'hA5);
      spi_wr(4'd7, 8'hFF);
      spi_rd(4'd8, d);
      check("R2 reserved write no busy", d, 8'h40);
      spi_rd(4'd7, d);
      check("R2 reserved read 7", d, 8'h00);
      spi_rd(4'd15, d);
      check("R2 reserved read 15", d, 8'h00);
   endtask

   task automatic t_abort_and_opcode();
      logic [7:0] d;
      spi_wr(4'd8, 8'hC0);
      spi_frame(4'd1, 2'b10, 8'h22, 12, d);
      check("R10 aborted frame ignored", w1(), 8'h6A);
      spi_wr(4'd1, 8'h22);
      check("R9 full frame writes ch1", w1(), 8'h22);
      spi_frame(4'd8, 2'b11, 8'h00, 16, d);
      spi_rd(4'd8, d);
      check("R9 opcode 11 no effect", d, 8'hC0);
      spi_frame(4'd1, 2'b00, 8'h55, 16, d);
      check("R9 opcode 00 no effect", w1(), 8'h22);
      spi_wr(4'd8, 8'h40);
   endtask

   initial begin
      t_powerup();
      t_ctrl_defaults();
      t_nv_write_busy();
      t_volatile_bank();
      t_ctrl_readonly();
      t_shutdown();
      t_gp_reserved();
      t_abort_and_opcode();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule